// File: doc/BRIEF.md
# Wrapping Burst Address Sequencer

This block generates word addresses for the data beats of a synchronous burst access to a pseudo-static RAM slave. A start address is taken from the address bus when the active-low address-valid strobe returns high while the active-low chip select is held low. From the next cycle on, the block presents one word address per beat. A beat-advance input moves it to the next word.

Three burst lengths are available: a short aligned burst (8 words by default), a long aligned burst (16 words by default), and an unbounded burst. In the aligned lengths the low address bits count up and wrap to zero at the top of the aligned block, while the upper bits stay fixed. The unbounded burst counts across the whole address space and ends only when chip select is deasserted. A separate mode input limits every write burst to a single beat and leaves read bursts at the configured length. The length code, the single-write mode and the read/write direction are all taken at the moment the address is captured.

Top module: `burst_addr_seq`

## Requirements
- R1: When `adv_n` is seen low on one clock edge and high on the next while `cs_n` is low, `addr_in` is captured on that second edge. From then on `beat_valid` is 1 and `word_addr` equals the captured address.
- R2: A rising edge of `adv_n` while `cs_n` is high captures nothing, and `beat_valid` stays 0.
- R3: Changes on `addr_in` after the capture edge have no effect on `word_addr` during the burst.
- R4: Each clock edge with `step` high during a burst makes the next address the previous one plus 1, subject to the wrap rules. With `step` low the address holds.
- R5: Length code `len_code`=2'b00 gives an 8-beat burst. Bits [2:0] wrap from 7 to 0 and all higher bits stay unchanged.
- R6: Length code 2'b01 gives a 16-beat burst. Bits [3:0] wrap from 15 to 0 and all higher bits stay unchanged.
- R7: Length code 2'b10 or 2'b11 gives an unbounded burst. The address wraps from all ones to zero, `burst_last` is never asserted, and the burst never ends by itself.
- R8: In a finite burst, `burst_last` is 1 exactly on the final beat. A `step` on that beat ends the burst, and `beat_valid` is 0 after that edge.
- R9: With `wr_single`=1, a write burst (`is_write`=1) has exactly one beat, with `burst_last` set, whatever the length code. Read bursts keep the configured length.
- R10: `cs_n` high ends any burst. `beat_valid` is 0 after the next clock edge.
- R11: `len_code`, `wr_single` and `is_write` are sampled at capture. Changing them during a burst does not alter that burst's length or wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select |
| adv_n | input | 1 | Active-low address-valid strobe |
| addr_in | input | ADDR_W | Word address bus |
| is_write | input | 1 | 1 for a write burst, 0 for a read burst |
| len_code | input | 2 | 00 short, 01 long, 1x unbounded |
| wr_single | input | 1 | 1 limits write bursts to one beat |
| step | input | 1 | Beat advance, one pulse per transferred word |
| word_addr | output | ADDR_W | Current beat word address |
| beat_valid | output | 1 | A burst beat is current |
| burst_last | output | 1 | Current beat is the final beat of a finite burst |

## Verification
The sequencing is exercised with the following start addresses:
- A short read burst starting mid-block, which shows the 3-bit wrap.
- Long bursts starting near the top of a 16-word block, which show the 4-bit wrap and separate it from the 3-bit wrap.
- A start at an aligned base, which shows a burst that never wraps.
- Write bursts with and without the single-write mode, plus a read burst under that mode. These pin the length to the direction.

An unbounded burst starting two words below the top of the address space shows the full-range wrap and the absence of any end. Directed cases stall `step`, abort through chip select, give a strobe with chip select high, and change the bus and the configuration in the middle of a burst. They separate the sampled inputs from the live ones.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
    localparam logic [1:0] LEN_SHORT = 2'b00;
    localparam logic [1:0] LEN_LONG  = 2'b01;

    function automatic logic len_is_open(input logic [1:0] code);
        return code[1];
    endfunction
endpackage

// File: rtl/burst_strobe_edge.sv
module burst_strobe_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic adv_n,
    output logic capture
);
    logic prev_d, prev_q;

    always_comb begin
        prev_d  = adv_n;
        capture = !prev_q && adv_n && !cs_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/burst_len_sel.sv
module burst_len_sel
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int SHORT_LEN = 8,
    parameter int LONG_LEN  = 16,
    parameter int CNT_W     = $clog2(LONG_LEN) + 1
) (
    input  logic [1:0]        len_code,
    input  logic              is_write,
    input  logic              wr_single,
    output logic [CNT_W-1:0]  beats,
    output logic [ADDR_W-1:0] wrap_mask,
    output logic              open_end
);
    always_comb begin
        open_end  = 1'b0;
        beats     = CNT_W'(SHORT_LEN);
        wrap_mask = ADDR_W'(SHORT_LEN - 1);
        if (is_write && wr_single) begin
            beats = CNT_W'(1);
        end else if (len_is_open(len_code)) begin
            open_end  = 1'b1;
            wrap_mask = '1;
        end else if (len_code == LEN_LONG) begin
            beats     = CNT_W'(LONG_LEN);
            wrap_mask = ADDR_W'(LONG_LEN - 1);
        end
    end
endmodule

// File: rtl/burst_addr_step.sv
module burst_addr_step #(
    parameter int ADDR_W = 16
) (
    input  logic [ADDR_W-1:0] cur,
    input  logic [ADDR_W-1:0] wrap_mask,
    output logic [ADDR_W-1:0] nxt
);
    logic [ADDR_W-1:0] inc;

    always_comb begin
        inc = cur + ADDR_W'(1);
        nxt = (cur & ~wrap_mask) | (inc & wrap_mask);
    end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq #(
    parameter int ADDR_W    = 16,
    parameter int SHORT_LEN = 8,
    parameter int LONG_LEN  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              adv_n,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              is_write,
    input  logic [1:0]        len_code,
    input  logic              wr_single,
    input  logic              step,
    output logic [ADDR_W-1:0] word_addr,
    output logic              beat_valid,
    output logic              burst_last
);
    localparam int CNT_W   = $clog2(LONG_LEN) + 1;
    localparam int LG_LONG = $clog2(LONG_LEN);

    typedef struct packed {
        logic              active;
        logic              open_end;
        logic [ADDR_W-1:0] addr;
        logic [ADDR_W-1:0] mask;
        logic [CNT_W-1:0]  remain;
    } seq_t;

    seq_t st_d, st_q;
    logic              capture;
    logic [CNT_W-1:0]  sel_beats;
    logic [ADDR_W-1:0] sel_mask;
    logic              sel_open;
    logic [ADDR_W-1:0] next_addr;

    burst_strobe_edge i_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_n    (cs_n),
        .adv_n   (adv_n),
        .capture (capture)
    );

    burst_len_sel #(
        .ADDR_W    (ADDR_W),
        .SHORT_LEN (SHORT_LEN),
        .LONG_LEN  (LONG_LEN),
        .CNT_W     (CNT_W)
    ) i_len (
        .len_code  (len_code),
        .is_write  (is_write),
        .wr_single (wr_single),
        .beats     (sel_beats),
        .wrap_mask (sel_mask),
        .open_end  (sel_open)
    );

    burst_addr_step #(.ADDR_W(ADDR_W)) i_step (
        .cur       (st_q.addr),
        .wrap_mask (st_q.mask),
        .nxt       (next_addr)
    );

    always_comb begin
        st_d = st_q;
        if (cs_n) begin
            st_d.active = 1'b0;
        end else if (capture) begin
            st_d.active   = 1'b1;
            st_d.open_end = sel_open;
            st_d.addr     = addr_in;
            st_d.mask     = sel_mask;
            st_d.remain   = sel_beats;
        end else if (st_q.active && step) begin
            if (!st_q.open_end && st_q.remain == CNT_W'(1)) begin
                st_d.active = 1'b0;
            end else begin
                st_d.addr = next_addr;
                if (!st_q.open_end) st_d.remain = st_q.remain - CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        word_addr  = st_q.addr;
        beat_valid = st_q.active;
        burst_last = st_q.active && !st_q.open_end && st_q.remain == CNT_W'(1);
    end

    logic adv_run;
    assign adv_run = beat_valid && step && !cs_n && !capture;

    AST_CAPTURE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> beat_valid && word_addr == $past(addr_in)); // R1
    AST_NO_CAPTURE_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> !beat_valid); // R10
    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid && !step && !cs_n && !capture |=> beat_valid && $stable(word_addr)); // R4
    AST_LOW_INCREMENT: assert property (@(posedge clk) disable iff (!rst_n)
        adv_run && !burst_last |=> word_addr[2:0] == $past(word_addr[2:0]) + 3'd1); // R4
    AST_UPPER_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        adv_run && !st_q.open_end |=> $stable(word_addr[ADDR_W-1:LG_LONG])); // R5
    AST_LAST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        adv_run && burst_last |=> !beat_valid); // R8
    AST_OPEN_NO_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid && st_q.open_end |-> !burst_last); // R7
endmodule

// File: tb/test_burst_addr_seq.sv
module test_burst_addr_seq;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cs_n = 1'b1;
    logic          adv_n = 1'b1;
    logic [AW-1:0] addr_in = '0;
    logic          is_write = 1'b0;
    logic [1:0]    len_code = 2'b00;
    logic          wr_single = 1'b0;
    logic          step = 1'b0;
    logic [AW-1:0] word_addr;
    logic          beat_valid;
    logic          burst_last;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    burst_addr_seq i_burst_addr_seq (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .adv_n(adv_n),
        .addr_in(addr_in), .is_write(is_write), .len_code(len_code),
        .wr_single(wr_single), .step(step), .word_addr(word_addr),
        .beat_valid(beat_valid), .burst_last(burst_last)
    );

    typedef struct packed {
        logic [AW-1:0] start;
        logic [1:0]    len;
        logic          ws;
        logic          wr;
        logic [4:0]    beats;
    } vec_t;

    localparam vec_t VECS [7] = '{
        '{16'h1235, 2'b00, 1'b0, 1'b0, 5'd8},   // R5 mid-block short read
        '{16'h12FE, 2'b01, 1'b0, 1'b0, 5'd16},  // R6 long read near top
        '{16'h4448, 2'b00, 1'b0, 1'b1, 5'd8},   // R5 aligned short write
        '{16'hA00D, 2'b01, 1'b0, 1'b1, 5'd16},  // R6 long write
        '{16'h4449, 2'b01, 1'b1, 1'b1, 5'd1},   // R9 single write
        '{16'h0005, 2'b00, 1'b1, 1'b0, 5'd8},   // R9 read keeps length
        '{16'h7777, 2'b10, 1'b1, 1'b1, 5'd1}    // R9 single write over open code
    };

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] nxt(input logic [AW-1:0] a, input logic [1:0] len);
        logic [AW-1:0] m;
        m = len[1] ? '1 : (len == 2'b01 ? AW'(15) : AW'(7));
        return (a & ~m) | ((a + 1'b1) & m);
    endfunction

    task automatic start_burst(input logic [AW-1:0] a, input logic [1:0] len, input logic ws, input logic wr);
        @(negedge clk);
        cs_n = 1'b0; adv_n = 1'b0; addr_in = a;
        len_code = len; wr_single = ws; is_write = wr;
        @(negedge clk);
        adv_n = 1'b1;
        @(negedge clk);
    endtask

    // Called right after start_burst, at a falling edge.
    task automatic walk(input logic [AW-1:0] a, input logic [1:0] len, input int beats,
                        input bit perturb, input string tag);
        logic [AW-1:0] e;
        e = a;
        for (int k = 0; k < beats; k++) begin
            chk(beat_valid === 1'b1, tag, {31'd0, beat_valid}, 32'd1);
            chk(word_addr === e, tag, {16'd0, word_addr}, {16'd0, e});
            chk(burst_last === (k == beats - 1), {tag, " R8 last"}, {31'd0, burst_last},
                {31'd0, k == beats - 1});
            if (perturb && k == 2) begin
                addr_in = ~a; len_code = 2'b10; wr_single = ~wr_single; is_write = ~is_write;
            end
            step = 1'b1;
            @(negedge clk);
            e = nxt(e, len);
        end
        chk(beat_valid === 1'b0, {tag, " R8 end"}, {31'd0, beat_valid}, 32'd0);
        step = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(beat_valid === 1'b0 && burst_last === 1'b0, "reset", {30'd0, beat_valid, burst_last}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(beat_valid === 1'b0, "reset R2", {31'd0, beat_valid}, 32'd0);

        for (int i = 0; i < 7; i++) begin
            start_burst(VECS[i].start, VECS[i].len, VECS[i].ws, VECS[i].wr);
            walk(VECS[i].start, VECS[i].len, int'(VECS[i].beats), 1'b0, "R1 R4 table");
        end

        // R3 R11: bus and configuration changes mid-burst are ignored
        start_burst(16'h0020, 2'b00, 1'b0, 1'b0);
        walk(16'h0020, 2'b00, 8, 1'b1, "R3 R11");

        // R7: unbounded burst wraps over the top, never ends, cs_n stops it (R10)
        begin
            logic [AW-1:0] e;
            e = 16'hFFFE;
            start_burst(16'hFFFE, 2'b11, 1'b0, 1'b0);
            for (int k = 0; k < 20; k++) begin
                chk(beat_valid === 1'b1 && burst_last === 1'b0, "R7 valid", {30'd0, beat_valid, burst_last}, 32'd2);
                chk(word_addr === e, "R7 addr", {16'd0, word_addr}, {16'd0, e});
                step = 1'b1;
                @(negedge clk);
                e = e + 1'b1;
            end
            step = 1'b0;
            cs_n = 1'b1;
            @(negedge clk);
            chk(beat_valid === 1'b0, "R10 open stop", {31'd0, beat_valid}, 32'd0);
        end

        // R4: stall holds the address; R10: abort of a finite burst
        start_burst(16'h0033, 2'b00, 1'b0, 1'b0);
        step = 1'b1; @(negedge clk); step = 1'b0;
        repeat (3) @(negedge clk);
        chk(word_addr === 16'h0034 && beat_valid === 1'b1, "R4 stall", {16'd0, word_addr}, 32'h34);
        cs_n = 1'b1;
        @(negedge clk);
        chk(beat_valid === 1'b0, "R10 abort", {31'd0, beat_valid}, 32'd0);

        // R2: strobe with chip select high captures nothing
        adv_n = 1'b0; addr_in = 16'h5555;
        @(negedge clk);
        adv_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk(beat_valid === 1'b0, "R2 deselected", {31'd0, beat_valid}, 32'd0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule